// File: doc/BRIEF.md
# PLD Row Programming Sequencer

This block produces the pin waveforms that move one row of bits into or out of a small electrically erasable logic device. A host sets a command, a six-bit row address, a row length, a row pattern and, for program cycles, a pulse length in milliseconds, then raises `start` for one clock. The sequencer drives the device's address lines, serial data line, serial clock, active-low load strobe and program/verify select. It samples the device's serial data output and shows the bits it read on `rd_data` when `done` pulses.

There are three sequences. A direct read strobes at once and then clocks the row out. A shifted read first clocks a pattern in, which is all zeros for fuse rows or a column selection for other rows, then strobes and clocks the row out. A program cycle raises program/verify, clocks the row in, and holds the strobe low for the programming pulse. It uses the same steps for write, erase, security and clear rows. Every wait is counted in system clocks from parameters. The programming pulse is counted through a microsecond and millisecond prescaler. Supply voltages, device type tables and fuse-number mapping are handled elsewhere.

Top module: `pld_row_sequencer`

## Requirements
- R1: After reset `pld_addr`=0, `pld_din`=0, `pld_clk`=0, `pld_prog`=0, `pld_load_n`=1, `busy`=0, `done`=0 and `rd_data`=0. Whenever `busy` is low, `pld_load_n` is high and `pld_clk` and `pld_prog` are low.
- R2: `pld_addr` takes `row_addr` at the edge that accepts `start`. It has been held at least SETUP_CYC clocks when the strobe falls, stays constant while busy, and returns to 0 when the command ends.
- R3: Every serial clock high pulse lasts exactly SCLK_HI_US*CLK_PER_US clocks. Between two pulses of one command the clock stays low at least SCLK_LO_US*CLK_PER_US clocks.
- R4: `cmd`=0 (direct read) gives one strobe low of STB_US*CLK_PER_US clocks before any clock pulse, followed by one clock pulse per row bit. `pld_din` stays low and `pld_prog` stays low throughout.
- R5: `cmd`=1 (shifted read) clocks the row pattern in, one pulse per bit, then gives one read strobe, then clocks the same number of bits out with `pld_din` low.
- R6: `cmd`=2 or 3 (program) raises `pld_prog` with the address, clocks the row in, and holds the strobe low exactly ms*US_PER_MS*CLK_PER_US clocks. It then releases the strobe and only afterwards lowers `pld_prog`. `pld_prog` never changes while the clock is high or the strobe is low.
- R7: Bit order. `row_data[0]` is shifted first and `row_data[i]` is the i-th bit shifted. `rd_data[i]` holds the device output sampled before the i-th read clock pulse, counting from 0. Bits at or above the row length read as 0, and a program cycle returns all zeros.
- R8: `pld_din` is stable at least SETUP_CYC clocks before each rising serial clock and does not change while the clock is high.
- R9: A row length of 0 gives no clock pulses. The strobe or programming pulse still occurs, so clear rows with 0 or 1 bit work.
- R10: `busy` is high from the clock after an accepted `start` until the command ends. `done` is a one-clock pulse in the first clock with `busy` low again. A `start` while busy is ignored.
- R11: A `pulse_ms` of 0 is treated as 1 ms.
- R12: A `row_len` above ROW_MAX is treated as ROW_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, accepted when not busy |
| cmd | input | 2 | 0 direct read, 1 shifted read, 2/3 program |
| row_addr | input | 6 | Row address for the device |
| row_len | input | LEN_W | Bits in the row |
| row_data | input | ROW_MAX | Pattern to shift in, bit 0 first |
| pulse_ms | input | MS_W | Programming pulse length in ms |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-command pulse |
| rd_data | output | ROW_MAX | Bits read, bit 0 first |
| pld_addr | output | 6 | Device row address lines |
| pld_din | output | 1 | Device serial data input |
| pld_clk | output | 1 | Device serial clock |
| pld_load_n | output | 1 | Device load strobe, active low |
| pld_prog | output | 1 | Device program/verify select |
| pld_dout | input | 1 | Device serial data output |

## Verification
The bench models the device's output shift register. The register reloads on the strobe and advances on each falling serial clock. A sequencer that samples one clock too late, or after the rising edge, therefore returns its row shifted by one bit. Zero-length rows and `pulse_ms` of 0 are tested, and a sequence that skipped the strobe or produced a zero-length pulse would show up as a wrong strobe width. An over-long `row_len` checks the clamp, where a broken counter would clock too many bits or never stop. A `start` raised in the middle of a program cycle would, if accepted, change the address or produce a second `done`.

// File: rtl/pld_seq_pkg.sv
package pld_seq_pkg;

    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        CMD_RD_DIRECT = 2'd0,
        CMD_RD_SHIFT  = 2'd1,
        CMD_PROGRAM   = 2'd2,
        CMD_PROGRAM_B = 2'd3
    } pld_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BIT_SET,
        ST_BIT_HI,
        ST_BIT_LO,
        ST_STB_RD,
        ST_STB_REC,
        ST_PULSE,
        ST_PV_OFF
    } pld_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              din;
        logic              sclk;
        logic              load_n;
        logic              prog;
    } pld_pins_t;

    localparam pld_pins_t PINS_IDLE = '{addr: '0, din: 1'b0, sclk: 1'b0,
                                        load_n: 1'b1, prog: 1'b0};

    function automatic logic cmd_is_program(input pld_cmd_e c);
        return c[1];
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pld_pulse_timer.sv
module pld_pulse_timer #(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000,
    parameter int MS_W       = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [MS_W-1:0] ms_target,
    output logic            last
);
    localparam int US_W  = $clog2(CLK_PER_US + 1);
    localparam int MSU_W = $clog2(US_PER_MS + 1);

    logic [US_W-1:0]  us_cnt;
    logic [MSU_W-1:0] ms_us;
    logic [MS_W-1:0]  ms_cnt;
    logic             us_wrap;
    logic             ms_wrap;

    assign us_wrap = (us_cnt == US_W'(CLK_PER_US - 1));
    assign ms_wrap = (ms_us == MSU_W'(US_PER_MS - 1));
    assign last    = run && us_wrap && ms_wrap && (ms_cnt == ms_target - MS_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            us_cnt <= '0;
            ms_us  <= '0;
            ms_cnt <= '0;
        end else if (us_wrap) begin
            us_cnt <= '0;
            if (ms_wrap) begin
                ms_us  <= '0;
                ms_cnt <= ms_cnt + MS_W'(1);
            end else begin
                ms_us <= ms_us + MSU_W'(1);
            end
        end else begin
            us_cnt <= us_cnt + US_W'(1);
        end
    end

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
        last |=> !run); // R6

endmodule

// File: rtl/pld_seq_ctrl.sv
module pld_seq_ctrl
    import pld_seq_pkg::*;
#(
    parameter int ROW_MAX   = 128,
    parameter int LEN_W     = 8,
    parameter int MS_W      = 8,
    parameter int SETUP_CYC = 2,
    parameter int HI_CYC    = 100,
    parameter int LO_CYC    = 100,
    parameter int STB_CYC   = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic [LEN_W-1:0]  row_len,
    input  logic [ROW_MAX-1:0] row_data,
    input  logic [MS_W-1:0]   pulse_ms,
    input  logic              sdout,
    input  logic              pulse_last,
    output logic              busy,
    output logic              done,
    output logic [ROW_MAX-1:0] rd_data,
    output pld_pins_t         pins,
    output logic              pulse_run,
    output logic [MS_W-1:0]   ms_q
);
    localparam int MAXC  = max_of4(SETUP_CYC, HI_CYC, LO_CYC, STB_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int IDX_W = $clog2(ROW_MAX);

    pld_state_e         st;
    pld_cmd_e           cmd_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   lim;
    logic               cnt_last;
    logic [IDX_W-1:0]   idx;
    logic               rd_phase;
    logic [LEN_W-1:0]   len_q;
    logic [ROW_MAX-1:0] data_q;
    logic [ROW_MAX-1:0] rd_q;
    logic               bit_last;
    logic               prog;

    always_comb begin
        case (st)
            ST_ADDR, ST_BIT_SET, ST_STB_REC, ST_PV_OFF: lim = CNT_W'(SETUP_CYC - 1);
            ST_BIT_HI:                                  lim = CNT_W'(HI_CYC - 1);
            ST_BIT_LO:                                  lim = CNT_W'(LO_CYC - 1);
            ST_STB_RD:                                  lim = CNT_W'(STB_CYC - 1);
            default:                                    lim = '0;
        endcase
    end

    assign cnt_last  = (cnt == lim);
    assign bit_last  = ((LEN_W'(idx) + LEN_W'(1)) == len_q);
    assign prog      = cmd_is_program(cmd_q);
    assign busy      = (st != ST_IDLE);
    assign rd_data   = rd_q;
    assign pulse_run = (st == ST_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cmd_q    <= CMD_RD_DIRECT;
            cnt      <= '0;
            idx      <= '0;
            rd_phase <= 1'b0;
            len_q    <= '0;
            data_q   <= '0;
            rd_q     <= '0;
            ms_q     <= '0;
            pins     <= PINS_IDLE;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            cnt  <= cnt_last ? '0 : cnt + CNT_W'(1);
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        cmd_q     <= pld_cmd_e'(cmd);
                        len_q     <= (row_len > LEN_W'(ROW_MAX)) ? LEN_W'(ROW_MAX) : row_len;
                        data_q    <= row_data;
                        rd_q      <= '0;
                        ms_q      <= (pulse_ms == '0) ? MS_W'(1) : pulse_ms;
                        idx       <= '0;
                        rd_phase  <= 1'b0;
                        pins.addr <= row_addr;
                        pins.prog <= cmd[1];
                        st        <= ST_ADDR;
                    end
                end
                ST_ADDR: if (cnt_last) begin
                    if (cmd_q == CMD_RD_DIRECT || len_q == '0) begin
                        pins.load_n <= 1'b0;
                        st          <= prog ? ST_PULSE : ST_STB_RD;
                    end else begin
                        pins.din <= data_q[0];
                        st       <= ST_BIT_SET;
                    end
                end
                ST_BIT_SET: if (cnt_last) begin
                    if (rd_phase) rd_q[idx] <= sdout;
                    pins.sclk <= 1'b1;
                    st        <= ST_BIT_HI;
                end
                ST_BIT_HI: if (cnt_last) begin
                    pins.sclk <= 1'b0;
                    st        <= ST_BIT_LO;
                end
                ST_BIT_LO: if (cnt_last) begin
                    if (bit_last) begin
                        if (rd_phase) begin
                            pins <= PINS_IDLE;
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            pins.din    <= 1'b0;
                            pins.load_n <= 1'b0;
                            st          <= prog ? ST_PULSE : ST_STB_RD;
                        end
                    end else begin
                        idx <= idx + IDX_W'(1);
                        st  <= ST_BIT_SET;
                        if (!rd_phase) begin
                            pins.din <= data_q[1];
                            data_q   <= data_q >> 1;
                        end
                    end
                end
                ST_STB_RD: if (cnt_last) begin
                    pins.load_n <= 1'b1;
                    st          <= ST_STB_REC;
                end
                ST_STB_REC: if (cnt_last) begin
                    if (len_q == '0) begin
                        pins <= PINS_IDLE;
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end else begin
                        rd_phase <= 1'b1;
                        idx      <= '0;
                        st       <= ST_BIT_SET;
                    end
                end
                ST_PULSE: begin
                    cnt <= '0;
                    if (pulse_last) begin
                        pins.load_n <= 1'b1;
                        st          <= ST_PV_OFF;
                    end
                end
                ST_PV_OFF: if (cnt_last) begin
                    pins <= PINS_IDLE;
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pins.load_n && !pins.sclk && !pins.prog)); // R1
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pins.addr)); // R2
    AST_NO_CLK_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(pins.sclk && !pins.load_n)); // R4
    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$stable(pins.prog) |-> (!pins.sclk && pins.load_n && !$past(pins.sclk) && $past(pins.load_n))); // R6
    AST_DIN_STEADY: assert property (@(posedge clk) disable iff (rst)
        (pins.sclk && $past(pins.sclk)) |-> $stable(pins.din)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(cmd_q)); // R10

endmodule

// File: rtl/pld_row_sequencer.sv
module pld_row_sequencer
    import pld_seq_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000,
    parameter int ROW_MAX    = 128,
    parameter int LEN_W      = 8,
    parameter int MS_W       = 8,
    parameter int SETUP_CYC  = 2,
    parameter int SCLK_HI_US = 2,
    parameter int SCLK_LO_US = 2,
    parameter int STB_US     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         cmd,
    input  logic [5:0]         row_addr,
    input  logic [LEN_W-1:0]   row_len,
    input  logic [ROW_MAX-1:0] row_data,
    input  logic [MS_W-1:0]    pulse_ms,
    output logic               busy,
    output logic               done,
    output logic [ROW_MAX-1:0] rd_data,
    output logic [5:0]         pld_addr,
    output logic               pld_din,
    output logic               pld_clk,
    output logic               pld_load_n,
    output logic               pld_prog,
    input  logic               pld_dout
);
    localparam int HI_CYC  = SCLK_HI_US * CLK_PER_US;
    localparam int LO_CYC  = SCLK_LO_US * CLK_PER_US;
    localparam int STB_CYC = STB_US * CLK_PER_US;

    pld_pins_t       pins;
    logic            pulse_run;
    logic            pulse_last;
    logic [MS_W-1:0] ms_q;

    pld_seq_ctrl #(
        .ROW_MAX  (ROW_MAX),
        .LEN_W    (LEN_W),
        .MS_W     (MS_W),
        .SETUP_CYC(SETUP_CYC),
        .HI_CYC   (HI_CYC),
        .LO_CYC   (LO_CYC),
        .STB_CYC  (STB_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (cmd),
        .row_addr  (row_addr),
        .row_len   (row_len),
        .row_data  (row_data),
        .pulse_ms  (pulse_ms),
        .sdout     (pld_dout),
        .pulse_last(pulse_last),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .pins      (pins),
        .pulse_run (pulse_run),
        .ms_q      (ms_q)
    );

    pld_pulse_timer #(
        .CLK_PER_US(CLK_PER_US),
        .US_PER_MS (US_PER_MS),
        .MS_W      (MS_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (pulse_run),
        .ms_target(ms_q),
        .last     (pulse_last)
    );

    assign pld_addr   = pins.addr;
    assign pld_din    = pins.din;
    assign pld_clk    = pins.sclk;
    assign pld_load_n = pins.load_n;
    assign pld_prog   = pins.prog;

endmodule

// File: tb/tb_pld_row_sequencer.sv
module tb_pld_row_sequencer;
    localparam int CPU = 2;
    localparam int UPM = 4;
    localparam int RMAX = 16;
    localparam int SET = 2;
    localparam int HI = 2 * CPU;
    localparam int LO = 1 * CPU;
    localparam int STB = 3 * CPU;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] cmd = '0;
    logic [5:0] row_addr = '0;
    logic [7:0] row_len = '0;
    logic [RMAX-1:0] row_data = '0;
    logic [7:0] pulse_ms = '0;
    logic busy, done;
    logic [RMAX-1:0] rd_data;
    logic [5:0] pld_addr;
    logic pld_din, pld_clk, pld_load_n, pld_prog;
    logic pld_dout;

    always #10 clk = ~clk;

    pld_row_sequencer #(
        .CLK_PER_US(CPU), .US_PER_MS(UPM), .ROW_MAX(RMAX), .LEN_W(8), .MS_W(8),
        .SETUP_CYC(SET), .SCLK_HI_US(2), .SCLK_LO_US(1), .STB_US(3)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .row_addr(row_addr),
        .row_len(row_len), .row_data(row_data), .pulse_ms(pulse_ms),
        .busy(busy), .done(done), .rd_data(rd_data), .pld_addr(pld_addr),
        .pld_din(pld_din), .pld_clk(pld_clk), .pld_load_n(pld_load_n),
        .pld_prog(pld_prog), .pld_dout(pld_dout)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    typedef struct {
        logic [5:0]  addr;
        int          nshift;
        logic [15:0] shift_bits;
        int          nread;
        logic [15:0] rd;
        int          stb_w;
        bit          is_prog;
    } exp_t;

    exp_t expq[$];

    // device model and observations
    logic [15:0] dev_row = '0;
    int  dptr = 0;
    assign pld_dout = (dptr < 16) ? dev_row[dptr] : 1'b0;

    logic p_clk = 0, p_ld = 1, p_din = 0, p_busy = 0, p_prog = 0;
    logic [5:0] p_addr = '0;
    int din_age = 0, addr_age = 0, hi_w = 0, lo_w = 0, stb_w = 0;
    int o_nshift = 0, o_nread = 0, o_stb = 0;
    logic [15:0] o_shift = '0;
    logic [5:0] o_addr = '0;
    bit seen_stb = 0, o_prog_at_stb = 0;
    int done_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            din_age  = (pld_din != p_din) ? 0 : din_age + 1;
            addr_age = (pld_addr != p_addr) ? 0 : addr_age + 1;
            if (pld_clk && !p_clk) begin
                chk(din_age >= SET, "R8 din setup", din_age, SET);
                if (o_nshift + o_nread > 0) chk(lo_w >= LO, "R3 clock low", lo_w, LO);
                if (!seen_stb) begin
                    if (o_nshift < 16) o_shift[o_nshift] = pld_din;
                    o_nshift++;
                end else begin
                    chk(pld_din == 1'b0, "R5 din low on read", pld_din, 0);
                    o_nread++;
                end
                hi_w = 0;
            end
            if (pld_clk) hi_w++;
            else lo_w++;
            if (!pld_clk && p_clk) begin
                chk(hi_w == HI, "R3 clock high width", hi_w, HI);
                lo_w = 0;
                if (seen_stb) dptr = dptr + 1;
            end
            if (!pld_load_n && p_ld) begin
                seen_stb = 1;
                dptr = 0;
                stb_w = 0;
                o_addr = pld_addr;
                o_prog_at_stb = pld_prog;
                chk(addr_age >= SET, "R2 addr setup", addr_age, SET);
            end
            if (!pld_load_n) stb_w++;
            if (pld_load_n && !p_ld) o_stb = stb_w;
            if (pld_prog != p_prog)
                chk(!pld_clk && pld_load_n, "R6 prog change", {pld_clk, pld_load_n}, 2'b01);
            if (busy && p_busy)
                chk(pld_addr == p_addr, "R2 addr held", pld_addr, p_addr);
            if (done) begin
                done_cnt++;
                chk(!busy, "R10 busy low at done", busy, 0);
                chk(pld_addr == 0, "R2 addr returns to 0", pld_addr, 0);
                if (expq.size() == 0) begin
                    chk(0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(o_addr == e.addr, "R2 addr at strobe", o_addr, e.addr);
                    chk(o_nshift == e.nshift, "R5/R9 shifted count", o_nshift, e.nshift);
                    chk(o_shift == e.shift_bits, "R7 shifted order", o_shift, e.shift_bits);
                    chk(o_nread == e.nread, "R4/R9 read count", o_nread, e.nread);
                    chk(rd_data == e.rd, "R7 read data", rd_data, e.rd);
                    chk(o_stb == e.stb_w, e.is_prog ? "R6 pulse width" : "R4 strobe width", o_stb, e.stb_w);
                    chk(o_prog_at_stb == e.is_prog, "R6 prog during strobe", o_prog_at_stb, e.is_prog);
                end
                o_nshift = 0; o_nread = 0; o_shift = '0; seen_stb = 0; o_stb = 0;
            end
            p_clk = pld_clk; p_ld = pld_load_n; p_din = pld_din;
            p_busy = busy; p_prog = pld_prog; p_addr = pld_addr;
        end
    end

    function automatic logic [15:0] lmask(input int l);
        return (l >= 16) ? 16'hFFFF : 16'((32'h1 << l) - 1);
    endfunction

    task automatic run_cmd(input logic [1:0] c, input logic [5:0] a, input int len,
                           input logic [15:0] d, input logic [7:0] pms,
                           input logic [15:0] dev, input bit poke);
        exp_t e;
        int l;
        int dc;
        l = (len > RMAX) ? RMAX : len;
        e.addr = a;
        e.is_prog = c[1];
        e.nshift = (c == 2'd0) ? 0 : l;
        e.shift_bits = (c == 2'd0) ? 16'h0 : (d & lmask(l));
        e.nread = c[1] ? 0 : l;
        e.rd = c[1] ? 16'h0 : (dev & lmask(l));
        e.stb_w = c[1] ? (((pms == 0) ? 1 : int'(pms)) * UPM * CPU) : STB;
        while (busy) @(negedge clk);
        dev_row = dev;
        cmd = c; row_addr = a; row_len = 8'(len); row_data = d; pulse_ms = pms;
        expq.push_back(e);
        dc = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10 busy after start", busy, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            cmd = 2'd0; row_addr = 6'h3F; row_len = 8'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == dc) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pld_load_n == 1'b1, "R1 strobe idles high", pld_load_n, 1);
        chk({pld_addr, pld_din, pld_clk, pld_prog} == 9'h0, "R1 pins low",
            {pld_addr, pld_din, pld_clk, pld_prog}, 0);
        chk(!busy && !done && rd_data == 0, "R1 status clear", {busy, done, rd_data}, 0);

        run_cmd(2'd0, 6'h15, 8, 16'h0, 8'd0, 16'hA5C3, 0);   // R4 direct read
        run_cmd(2'd1, 6'h2A, 12, 16'h0F0, 8'd0, 16'h3C5A, 0); // R5 shifted read
        run_cmd(2'd1, 6'h01, 16, 16'h0, 8'd0, 16'h8001, 0);  // R7 full row
        run_cmd(2'd2, 6'h07, 10, 16'h2B5, 8'd3, 16'hFFFF, 0); // R6 program
        run_cmd(2'd3, 6'h3F, 0, 16'h0, 8'd0, 16'h0, 0);      // R9 R11 clear row
        run_cmd(2'd2, 6'h3E, 1, 16'h1, 8'd1, 16'h0, 0);      // R9 one-bit row
        run_cmd(2'd0, 6'h10, 0, 16'h0, 8'd0, 16'hFFFF, 0);   // R9 read zero length
        run_cmd(2'd1, 6'h22, 20, 16'hC3A5, 8'd0, 16'h5A96, 0); // R12 clamp
        run_cmd(2'd2, 6'h0B, 4, 16'h9, 8'd2, 16'h0, 1);      // R10 start ignored
        begin
            int dc;
            dc = done_cnt;
            repeat (60) @(negedge clk);
            chk(done_cnt == dc && !busy, "R10 ignored start left no command", done_cnt, dc);
            chk(expq.size() == 0, "R10 all results seen", expq.size(), 0);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule